// File: doc/BRIEF.md
# Pin Change-Detect Interrupt Register

This block watches eight input pins, grouped as two ports of four. For each pin it holds a reference bit that software owns. It raises that pin's interrupt-state bit whenever the synchronized pin level differs from the reference. The interrupt is therefore a live mismatch and not a latched edge. If the pin returns to the reference level before software reacts, the interrupt-state bit drops again.

Software acknowledges an interrupt by writing a command. A set-reference command bit forces the reference to 1, which accepts a rising edge. A clear-reference command bit forces it to 0, which accepts a falling edge. Either command clears the interrupt-state bit for one cycle. After that cycle the bit follows the comparison against the new reference.

All access goes through one 32-bit register on a single-cycle bus. Reading the reference tells software the direction of the edge:
- interrupt set with reference 0 means a low-to-high change;
- interrupt set with reference 1 means a high-to-low change.

One output, the OR of all eight interrupt-state bits, serves as the combined interrupt.

Top module: `pin_change_irq`

## Requirements
- R1: After reset, every reference bit and every interrupt-state bit is 0, so `rd_data` reads 0 and `irq_o` is low.
- R2: `rd_data[7:0]` holds the interrupt state and `rd_data[15:8]` holds the reference. In each 8-bit field, bit k (k = 0..3) belongs to port 0 pin k, and bit 4+k belongs to port 1 pin k.
- R3: A pin level that differs from its reference sets that pin's interrupt-state bit. A pin change applied between clock edges shows in `rd_data` after the third following rising edge (two synchronizer flops plus the state flop), and not after the second.
- R4: A write with 1 in bit 16+i of `wr_data` (set-reference field, bits [23:16]) makes reference i equal to 1 and clears interrupt-state bit i at that edge.
- R5: A write with 1 in bit 24+i of `wr_data` (clear-reference field, bits [31:24]) makes reference i equal to 0 and clears interrupt-state bit i at that edge.
- R6: If the pin still differs from the reference after an acknowledge, interrupt-state bit i sets again at the next rising edge.
- R7: Set and clear command bits for the same pin written together leave the reference unchanged, but still clear the interrupt-state bit.
- R8: `rd_data[31:16]` (the command fields) always reads 0.
- R9: `irq_o` is high exactly when any interrupt-state bit is 1.
- R10: A write with no command bits set (only bits [15:0] nonzero) changes neither the references nor the interrupt state.
- R11: If a pin returns to its reference level without any acknowledge, its interrupt-state bit returns to 0, with the same three-edge latency as R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin levels, port 0 in [3:0], port 1 in [7:4] |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data; only bits [31:16] carry commands |
| rd_data | output | 32 | Register read value |
| irq_o | output | 1 | OR of all interrupt-state bits |

## Verification
A wrong reference bit shows up in two ways:
- it appears directly in `rd_data[15:8]` in the cycle after the write that should have set it;
- one edge later it shows as a spurious or missing interrupt-state bit, because the comparison runs against the wrong level.

A broken synchronizer depth or state flop moves the interrupt by a whole cycle, so the bench samples both the cycle before and the cycle of the expected assertion. A faulty acknowledge, such as a command on the wrong pin or set/clear priority where none should exist, shows at the ports one edge after the write, both in the reference byte and on `irq_o`.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
   // Field order inside the register, lowest field first.
   localparam int unsigned FLD_STATE = 0;
   localparam int unsigned FLD_REF   = 1;
   localparam int unsigned FLD_SET   = 2;
   localparam int unsigned FLD_CLR   = 3;
   localparam int unsigned NUM_FLDS  = 4;

   function automatic int unsigned fld_lo(input int unsigned fld, input int unsigned fw);
      return fld * fw;
   endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_ref_cell.sv
module pin_ref_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic set_cmd,
   input  logic clr_cmd,
   output logic ref_o,
   output logic state_o
);
   logic ref_q, state_q, ack;

   assign ack = set_cmd | clr_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q   <= 1'b0;
         state_q <= 1'b0;
      end else begin
         if (set_cmd && !clr_cmd)      ref_q <= 1'b1;
         else if (clr_cmd && !set_cmd) ref_q <= 1'b0;
         state_q <= ack ? 1'b0 : (pin_s ^ ref_q);
      end
   end

   assign ref_o   = ref_q;
   assign state_o = state_q;

   // R4 / R5: an acknowledge clears the interrupt state at the next edge
   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !state_o);
   a_r4_set_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cmd && !clr_cmd) |=> ref_o);
   a_r5_clr_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd && !set_cmd) |=> !ref_o);
   a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_cmd && clr_cmd) |=> $stable(ref_o));
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> $stable(ref_o));
   a_r3_state_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && (pin_s != ref_o)) |=> state_o);
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
   parameter int unsigned NUM_PORTS     = 2,
   parameter int unsigned PINS_PER_PORT = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned BUS_W         = 32
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_PORTS*PINS_PER_PORT-1:0]   pin_i,
   input  logic                                 wr_en,
   input  logic [BUS_W-1:0]                     wr_data,
   output logic [BUS_W-1:0]                     rd_data,
   output logic                                 irq_o
);
   import pin_change_irq_pkg::*;

   localparam int unsigned FW     = NUM_PORTS * PINS_PER_PORT;
   localparam int unsigned SET_LO = fld_lo(FLD_SET, FW);
   localparam int unsigned CLR_LO = fld_lo(FLD_CLR, FW);
   localparam int unsigned REF_LO = fld_lo(FLD_REF, FW);
   localparam int unsigned STA_LO = fld_lo(FLD_STATE, FW);

   if (BUS_W != NUM_FLDS * FW) begin : g_bad_width
      $error("pin_change_irq: BUS_W must equal four fields of NUM_PORTS*PINS_PER_PORT bits");
   end

   logic [FW-1:0] pin_s, set_cmd, clr_cmd, ref_v, state_v;
   logic [STA_LO+REF_LO-1:0] unused_low_wdata;

   assign unused_low_wdata = wr_data[STA_LO+REF_LO-1:0];

   pin_sync #(.WIDTH(FW), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pin_i),
      .sync_o  (pin_s)
   );

   assign set_cmd = wr_en ? wr_data[SET_LO +: FW] : '0;
   assign clr_cmd = wr_en ? wr_data[CLR_LO +: FW] : '0;

   for (genvar i = 0; i < FW; i++) begin : g_cell
      pin_ref_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin_s   (pin_s[i]),
         .set_cmd (set_cmd[i]),
         .clr_cmd (clr_cmd[i]),
         .ref_o   (ref_v[i]),
         .state_o (state_v[i])
      );
   end

   always_comb begin
      rd_data                  = '0;
      rd_data[STA_LO +: FW]    = state_v;
      rd_data[REF_LO +: FW]    = ref_v;
   end

   assign irq_o = |state_v;

   // R9: combined interrupt agrees with the read-back state byte
   a_r9_irq_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (rd_data[STA_LO +: FW] != '0));
endmodule

// File: tb/pin_change_irq_test.sv
module pin_change_irq_test;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] rd;
      logic        irq;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_i = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_o;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_change_irq uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_i),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_o   (irq_o)
   );

   // Monitor: pops each expected item and compares against the ports.
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rd_data !== e.rd || irq_o !== e.irq) begin
               errors++;
               $display("FAIL %s rd_data=%08h irq=%0b expected rd_data=%08h irq=%0b",
                        e.tag, rd_data, irq_o, e.rd, e.irq);
            end
         end
      end
   end

   task automatic expect_now(input logic [31:0] rd, input string tag);
      exp_t e;
      #1;
      e.rd  = rd;
      e.irq = (rd[7:0] != 8'h00);
      e.tag = tag;
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   initial begin
      tick(2);
      expect_now(32'h0, "R1 reset value");
      @(negedge clk); rst_n = 1'b1;
      tick(2);
      expect_now(32'h0, "R1 idle after reset");

      pin_i = 8'h01;
      tick(2);
      expect_now(32'h0, "R3 not yet after two edges");
      tick(1);
      expect_now(32'h0000_0001, "R3 rising mismatch, R9 irq");

      pin_i = 8'h00;
      tick(3);
      expect_now(32'h0, "R11 pin back to reference");

      pin_i = 8'h01;
      tick(3);
      expect_now(32'h0000_0001, "R3 mismatch again");
      bus_write(32'h0001_0000);
      expect_now(32'h0000_0100, "R4 set reference and clear state");
      tick(1);
      expect_now(32'h0000_0100, "R4 stays acknowledged");

      pin_i = 8'h00;
      tick(3);
      expect_now(32'h0000_0101, "R2 falling edge decode ref=1");
      bus_write(32'h0100_0000);
      expect_now(32'h0, "R5 clear reference and state");

      pin_i = 8'h80;
      tick(3);
      expect_now(32'h0000_0080, "R2 port1 pin3 in bit 7");
      bus_write(32'h8000_0000);
      expect_now(32'h0, "R5 ack clears state for one cycle");
      tick(1);
      expect_now(32'h0000_0080, "R6 reasserts while mismatched");
      bus_write(32'h0080_0000);
      expect_now(32'h0000_8000, "R4 port1 reference in bit 15");
      tick(1);
      expect_now(32'h0000_8000, "R4 matched after set");

      pin_i = 8'h90;
      tick(3);
      expect_now(32'h0000_8010, "R3 port1 pin0 in bit 4");
      bus_write(32'h1010_0000);
      expect_now(32'h0000_8000, "R7 both commands hold ref, clear state");
      tick(1);
      expect_now(32'h0000_8010, "R7 reference unchanged so state returns");
      bus_write(32'h0000_FFFF);
      expect_now(32'h0000_8010, "R10 no-command write ignored");
      expect_now(32'h0000_8010, "R8 command fields read zero");

      pin_i = 8'h93;
      tick(3);
      expect_now(32'h0000_8013, "R9 several pins pending");
      bus_write(32'h0013_0000);
      expect_now(32'h0000_9300, "R4 multi-pin acknowledge");
      tick(1);
      expect_now(32'h0000_9300, "R9 irq low when all matched");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule